// File: doc/BRIEF.md
# Edge/Level Interrupt Request Capture

This block is the request-capture and priority stage of a sixteen-input interrupt controller organised as two banks of eight lines. Every clock it samples all request lines and updates a per-line pending register. A per-line trigger select decides how each line is captured. In level mode the pending bit tracks the line. In edge mode a stored copy of the previous line level lets only a low-to-high change raise a request, so a line that stays high raises no further requests.

A mask vector hides pending bits from priority resolution. Line 0 has the highest priority. The request output is raised when the best unmasked pending line outranks the best in-service line. An acknowledge pulse moves the winning line into service and returns its number. An end-of-interrupt pulse retires the highest-priority in-service line.

Top module: `irq_capture_top`

## Requirements
- R1: A synchronous active-low reset clears all pending, in-service and stored-level state. While it is held, `irq_out` is 0 and `ack_id` is 0.
- R2: A line whose `trig_sel` bit is 1 is level triggered. Its pending bit after a clock edge equals the line value sampled at that edge, whether the line is high or low.
- R3: A line whose `trig_sel` bit is 0 is edge triggered. A high sample whose previous sample was low sets its pending bit at that edge.
- R4: On an edge-triggered line a low sample leaves an already set pending bit set.
- R5: On an edge-triggered line a high sample that follows a high sample creates no request. After an acknowledge has cleared the bit, it stays clear while the line stays high.
- R6: A line whose `mask` bit is 1 is not considered for `irq_out` or `ack_id`. Its pending bit is kept.
- R7: `ack_id` is the lowest-numbered line that is pending and unmasked, or 0 when there is none.
- R8: `irq_out` is 1 exactly when an unmasked pending line exists and either nothing is in service or that line's number is lower than the lowest in-service number.
- R9: An `ack` pulse while an unmasked line is pending sets the in-service bit of the `ack_id` line. It clears that line's pending bit only if the line is edge triggered.
- R10: An `eoi` pulse clears only the lowest-numbered set in-service bit.
- R11: Line n is held in bank n>>3 at bit n&7. Bit n of `irr_out` and `isr_out` belongs to line n for every line of both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 16 | Request lines, sampled every clock |
| trig_sel | input | 16 | Per-line trigger: 1 level, 0 edge |
| mask | input | 16 | Per-line mask: 1 hides the line from resolution |
| ack | input | 1 | Acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| irq_out | output | 1 | Request to the processor |
| ack_id | output | 4 | Number of the winning pending line |
| irr_out | output | 16 | Pending register |
| isr_out | output | 16 | In-service register |

## Verification
The bench drives single lines in both banks to show the bank and bit mapping. It raises and lowers level lines and edge lines so that tracking is told apart from latching. An edge line is held high across an acknowledge to show that the repeat is dropped, and is then lowered and raised again to show that a fresh edge is still caught. Several lines pend at once, with and without in-service lines at higher, equal or lower rank, to separate the priority, mask and nesting rules. Acknowledges are given to both edge and level lines to show where the pending bit is cleared.

// File: rtl/irqc_pkg.sv
// Shared definitions for the interrupt request capture block.
// Assumes: trigger encoding 0 = edge, 1 = level.
package irqc_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/irqc_bank.sv
// One bank of request capture: pending bits and stored last-level bits.
// Assumes: clr_req only affects edge lines. A clear wins over a same-cycle edge.
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_in,
    input  logic [WIDTH-1:0] lvl_sel,
    input  logic [WIDTH-1:0] clr_req,
    output logic [WIDTH-1:0] pend
);
    logic [WIDTH-1:0] last_lvl;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        // Capture one line according to its trigger mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i]     <= 1'b0;
                last_lvl[i] <= 1'b0;
            end else if (trig_e'(lvl_sel[i]) == TRIG_LEVEL) begin
                pend[i]     <= line_in[i];
                last_lvl[i] <= line_in[i];
            end else begin
                last_lvl[i] <= line_in[i];
                if (clr_req[i])
                    pend[i] <= 1'b0;
                else if (line_in[i] && !last_lvl[i])
                    pend[i] <= 1'b1;
            end
        end

        // R2
        lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_sel[i] |=> (pend[i] == $past(line_in[i])));
        // R4
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lvl_sel[i] && pend[i] && !clr_req[i]) |=> pend[i]);
        // R5
        edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lvl_sel[i] && !pend[i] && last_lvl[i] && line_in[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority finder: reports the lowest set bit index of a vector.
// Assumes: index 0 is highest priority. The index is 0 when nothing is set.
module irqc_prio #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_capture_top.sv
// Request capture, priority and in-service tracking for a two-bank controller.
// Assumes: ack and eoi are single-cycle pulses. With both in one cycle, eoi
// retires first, then ack loads the new winner.
module irq_capture_top #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] req_in,
    input  logic [15:0] trig_sel,
    input  logic [15:0] mask,
    input  logic        ack,
    input  logic        eoi,
    output logic        irq_out,
    output logic [3:0]  ack_id,
    output logic [15:0] irr_out,
    output logic [15:0] isr_out
);
    localparam int NUM_PINS = NUM_BANKS * BANK_W;
    localparam int ID_W     = $clog2(NUM_PINS);

    logic [NUM_PINS-1:0] irr, isr, clr_vec, pend_vec;
    logic                pend_found, isr_found;
    logic [ID_W-1:0]     pend_idx, isr_idx;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_bank #(.WIDTH(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (req_in[b*BANK_W +: BANK_W]),
            .lvl_sel (trig_sel[b*BANK_W +: BANK_W]),
            .clr_req (clr_vec[b*BANK_W +: BANK_W]),
            .pend    (irr[b*BANK_W +: BANK_W])
        );
    end

    assign pend_vec = irr & ~mask;

    irqc_prio #(.N(NUM_PINS), .IW(ID_W)) u_pend_prio (
        .vec (pend_vec), .found (pend_found), .idx (pend_idx)
    );
    irqc_prio #(.N(NUM_PINS), .IW(ID_W)) u_isr_prio (
        .vec (isr), .found (isr_found), .idx (isr_idx)
    );

    // Pending clear on acknowledge, limited to edge lines.
    always_comb begin
        clr_vec = '0;
        if (ack && pend_found) clr_vec[pend_idx] = 1'b1;
        clr_vec = clr_vec & ~trig_sel;
    end

    // In-service update: retire the best bit on eoi, load the winner on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr <= '0;
        end else begin
            logic [NUM_PINS-1:0] nxt;
            nxt = isr;
            if (eoi && isr_found) nxt[isr_idx] = 1'b0;
            if (ack && pend_found) nxt[pend_idx] = 1'b1;
            isr <= nxt;
        end
    end

    assign irq_out = pend_found && (!isr_found || (pend_idx < isr_idx));
    assign ack_id  = pend_idx;
    assign irr_out = irr;
    assign isr_out = isr;

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|(irr_out & ~mask)));
    // R9
    ack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && |(irr_out & ~mask)) |=> isr_out[$past(ack_id)]);
    // R10
    eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && |isr_out) |=> ($countones(isr_out) == $countones($past(isr_out)) - 1));
endmodule

// File: tb/irq_capture_top_test.sv
module irq_capture_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_in = '0, trig_sel = '0, mask = '0;
    logic        ack = 1'b0, eoi = 1'b0;
    logic        irq_out;
    logic [3:0]  ack_id;
    logic [15:0] irr_out, isr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [15:0] irr;
        logic [15:0] isr;
        logic        irq;
        logic [3:0]  id;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    irq_capture_top uut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_sel(trig_sel),
        .mask(mask), .ack(ack), .eoi(eoi), .irq_out(irq_out),
        .ack_id(ack_id), .irr_out(irr_out), .isr_out(isr_out)
    );

    // Monitor: after each edge, pop one expected item and compare.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks += 4;
            if (irr_out !== e.irr) begin
                n_fail++;
                $display("FAIL %s irr act=%h exp=%h", e.tag, irr_out, e.irr);
            end
            if (isr_out !== e.isr) begin
                n_fail++;
                $display("FAIL %s isr act=%h exp=%h", e.tag, isr_out, e.isr);
            end
            if (irq_out !== e.irq) begin
                n_fail++;
                $display("FAIL %s irq act=%b exp=%b", e.tag, irq_out, e.irq);
            end
            if (ack_id !== e.id) begin
                n_fail++;
                $display("FAIL %s id act=%0d exp=%0d", e.tag, ack_id, e.id);
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue the expected state.
    task automatic step(input logic [15:0] r, input logic a, input logic e,
                        input logic [15:0] xirr, input logic [15:0] xisr,
                        input logic xirq, input logic [3:0] xid, input string tag);
        exp_t it;
        @(negedge clk);
        req_in = r;
        ack    = a;
        eoi    = e;
        it.irr = xirr; it.isr = xisr; it.irq = xirq; it.id = xid; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        trig_sel = 16'h0F00;
        // R1: reset held with all lines high
        step(16'hFFFF, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd0, "R1");
        step(16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        step(16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd0, "R1");
        // R3 R11: edge line 5 rises
        step(16'h0020, 1'b0, 1'b0, 16'h0020, 16'h0000, 1'b1, 4'd5, "R3");
        // R4: line falls, pending stays
        step(16'h0000, 1'b0, 1'b0, 16'h0020, 16'h0000, 1'b1, 4'd5, "R4");
        // R2 R11: level line 9 in upper bank tracks high then low
        step(16'h0200, 1'b0, 1'b0, 16'h0220, 16'h0000, 1'b1, 4'd5, "R2");
        step(16'h0000, 1'b0, 1'b0, 16'h0020, 16'h0000, 1'b1, 4'd5, "R2");
        // R7: lines 3 and 15 join, 3 wins
        step(16'h8008, 1'b0, 1'b0, 16'h8028, 16'h0000, 1'b1, 4'd3, "R7");
        // R9: ack edge line 3
        step(16'h0000, 1'b1, 1'b0, 16'h8020, 16'h0008, 1'b0, 4'd5, "R9");
        // R8: lower rank pending is held back
        step(16'h0000, 1'b0, 1'b0, 16'h8020, 16'h0008, 1'b0, 4'd5, "R8");
        // R8: line 0 outranks in-service 3
        step(16'h0001, 1'b0, 1'b0, 16'h8021, 16'h0008, 1'b1, 4'd0, "R8");
        step(16'h0000, 1'b1, 1'b0, 16'h8020, 16'h0009, 1'b0, 4'd5, "R9");
        // R10: eoi retires 0 first, then 3
        step(16'h0000, 1'b0, 1'b1, 16'h8020, 16'h0008, 1'b0, 4'd5, "R10");
        step(16'h0000, 1'b0, 1'b1, 16'h8020, 16'h0000, 1'b1, 4'd5, "R10");
        // R6: masks hide lines but keep pending bits
        @(negedge clk); mask = 16'h0020;
        step(16'h0000, 1'b0, 1'b0, 16'h8020, 16'h0000, 1'b1, 4'd15, "R6");
        @(negedge clk); mask = 16'h8020;
        step(16'h0000, 1'b0, 1'b0, 16'h8020, 16'h0000, 1'b0, 4'd0, "R6");
        @(negedge clk); mask = 16'h0020;
        // R9: ack of level line 10 keeps its pending bit
        step(16'h0400, 1'b0, 1'b0, 16'h8420, 16'h0000, 1'b1, 4'd10, "R2");
        step(16'h0400, 1'b1, 1'b0, 16'h8420, 16'h0400, 1'b0, 4'd10, "R9");
        step(16'h0000, 1'b0, 1'b1, 16'h8020, 16'h0000, 1'b1, 4'd15, "R10");
        // R5: edge line 1 held high across its ack
        step(16'h0002, 1'b0, 1'b0, 16'h8022, 16'h0000, 1'b1, 4'd1, "R3");
        step(16'h0002, 1'b1, 1'b0, 16'h8020, 16'h0002, 1'b0, 4'd15, "R9");
        step(16'h0002, 1'b0, 1'b0, 16'h8020, 16'h0002, 1'b0, 4'd15, "R5");
        step(16'h0002, 1'b0, 1'b0, 16'h8020, 16'h0002, 1'b0, 4'd15, "R5");
        step(16'h0000, 1'b0, 1'b1, 16'h8020, 16'h0000, 1'b1, 4'd15, "R10");
        step(16'h0002, 1'b0, 1'b0, 16'h8022, 16'h0000, 1'b1, 4'd1, "R3");
        step(16'h0000, 1'b0, 1'b0, 16'h8022, 16'h0000, 1'b1, 4'd1, "R4");
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            finish_run();
        end
    end
endmodule